// File: doc/BRIEF.md
# I2C Controller Interrupt Register Bank

This block holds the interrupt state of an I2C controller. Twelve event sources feed a raw status word. Ten of them arrive as single-cycle pulses from the controller datapath and are held in flops until software clears them. The other two, receive-FIFO-full and transmit-FIFO-empty, are levels that track the FIFO state directly. A software-written enable word selects which raw bits reach the masked status word and the single interrupt line. When the controller signals a transmit abort, the block also records a cause vector that explains the abort.

Software clears events by reading, not by writing. Each pulsed source has its own clear address. A read there drops only that bit, so events on other sources that arrive during the interrupt handler are never lost. A combined clear address drops every pulsed bit at once. The abort-cause word has its own clearing rule, tied to the abort source's individual clear address. Reads return data one cycle after the read strobe.

Top module: `ic_irq_bank`

## Requirements
- R1: The raw status word reads at offset 0x34 with this bit layout: bit0 receive underflow, bit1 receive overflow, bit2 receive full, bit3 transmit overflow, bit4 transmit empty, bit5 read request, bit6 transmit abort, bit7 receive done, bit8 activity, bit9 stop seen, bit10 start seen, bit11 general call.
- R2: A pulse on `evt_i[n]`, for any n other than 2 and 4, sets raw bit n. The bit stays set until it is cleared by a read.
- R3: Raw bit2 equals `rx_full_i` and raw bit4 equals `tx_empty_i`. `evt_i[2]`, `evt_i[4]` and all clear reads have no effect on these two bits.
- R4: The enable word is written and read at offset 0x30 (12 bits) and resets to zero. `irq_o` is low after reset.
- R5: The masked status word at offset 0x2C equals raw status AND the enable word. `irq_o` is high exactly when the masked status word is non-zero.
- R6: The pulsed sources, taken in ascending bit order (0,1,3,5,6,7,8,9,10,11), have individual clear offsets 0x44 + 4*k, where k is the position in that list. A read there returns the bit's value before the clear in `rd_data_o[0]`, and it clears only that bit.
- R7: A read of offset 0x40 clears every pulsed bit and returns, in bit0, the OR of those bits before the clear.
- R8: An event pulse in the same cycle as a clear read of its bit (individual or combined) leaves the bit set.
- R9: When `evt_i[6]` pulses, `abort_cause_i` is ORed into the abort-cause word, read at offset 0x80. The cause layout is: bit0 7-bit address NACK, bit1 first 10-bit address byte NACK, bit2 second 10-bit address byte NACK, bit3 data NACK, bit4 general call NACK, bit5 read after general call, bit7 start byte ACKed, bit9 start byte with restart off, bit10 10-bit read with restart off, bit11 controller disabled.
- R10: Reading the transmit-abort clear offset 0x54 zeroes the abort-cause word, unless a new abort pulse arrives in the same cycle, in which case the word holds that pulse's cause. The combined clear at 0x40 leaves the abort-cause word unchanged.
- R11: `rd_data_o` takes the addressed value one clock after `rd_en_i` and holds it until the next read. Reads of unmapped offsets return zero. Writes to any offset other than 0x30 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (8) | Register byte offset |
| rd_en_i | input | 1 | Read strobe; clear offsets act on it |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 12 | Write data (enable word) |
| rd_data_o | output | DATA_W (32) | Registered read data |
| evt_i | input | 12 | Single-cycle event pulses, bit layout as R1 |
| rx_full_i | input | 1 | Receive FIFO full level |
| tx_empty_i | input | 1 | Transmit FIFO empty level |
| abort_cause_i | input | CAUSE_W (12) | Abort cause vector, valid with `evt_i[6]` |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong internal state always shows up at the ports. A latched bit that is wrongly set or lost changes the raw word on the very next read of 0x34. If that bit is enabled, it also changes `irq_o` in the cycle right after the faulty edge. A mis-decoded clear offset shows up as a neighbouring bit going missing from the raw word on the read that follows. A dropped same-cycle event shows up as a zero where a one is expected, one read later. Faults in the abort-cause word appear only through offset 0x80, so the tests read it after each abort pulse and after each kind of clear.

// File: rtl/ic_irq_pkg.sv
package ic_irq_pkg;
  localparam int unsigned SRC_W = 12;

  localparam int unsigned B_RX_UNDER  = 0;
  localparam int unsigned B_RX_OVER   = 1;
  localparam int unsigned B_RX_FULL   = 2;
  localparam int unsigned B_TX_OVER   = 3;
  localparam int unsigned B_TX_EMPTY  = 4;
  localparam int unsigned B_RD_REQ    = 5;
  localparam int unsigned B_TX_ABRT   = 6;
  localparam int unsigned B_RX_DONE   = 7;
  localparam int unsigned B_ACTIVITY  = 8;
  localparam int unsigned B_STOP_DET  = 9;
  localparam int unsigned B_START_DET = 10;
  localparam int unsigned B_GEN_CALL  = 11;

  // Sources that follow a level instead of being latched
  localparam logic [SRC_W-1:0] LEVEL_MASK = SRC_W'((1 << B_RX_FULL) | (1 << B_TX_EMPTY));

  localparam logic [7:0] OFS_MSTAT    = 8'h2C;
  localparam logic [7:0] OFS_ENABLE   = 8'h30;
  localparam logic [7:0] OFS_RAW      = 8'h34;
  localparam logic [7:0] OFS_CLR_ALL  = 8'h40;
  localparam logic [7:0] OFS_CLR_BASE = 8'h44;
  localparam logic [7:0] OFS_ABORT    = 8'h80;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_MSTAT,
    RS_ENABLE,
    RS_RAW,
    RS_CLR_ONE,
    RS_CLR_ALL,
    RS_ABORT
  } rd_sel_e;

  // Individual clear offset of a latched source: ranked among latched bits
  function automatic logic [7:0] clr_ofs(input int unsigned b);
    int unsigned k;
    k = 0;
    for (int unsigned i = 0; i < SRC_W; i++) begin
      if (i < b && !LEVEL_MASK[i]) k++;
    end
    return OFS_CLR_BASE + 8'(4 * k);
  endfunction
endpackage

// File: rtl/ic_irq_decode.sv
module ic_irq_decode
  import ic_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  output logic [SRC_W-1:0]  clr_vec_o,
  output logic [SRC_W-1:0]  clr_pick_o,
  output logic              clr_all_o,
  output logic              abort_clr_o,
  output logic              enable_we_o,
  output rd_sel_e           rd_sel_o
);
  logic [SRC_W-1:0] pick;

  for (genvar i = 0; i < SRC_W; i++) begin : g_pick
    if (LEVEL_MASK[i]) begin : g_level
      assign pick[i] = 1'b0;
    end else begin : g_latched
      localparam logic [7:0] MY_OFS = clr_ofs(i);
      assign pick[i] = rd_en_i && (addr_i == ADDR_W'(MY_OFS));
    end
  end

  always_comb begin
    clr_all_o   = rd_en_i && (addr_i == ADDR_W'(OFS_CLR_ALL));
    abort_clr_o = pick[B_TX_ABRT];
    enable_we_o = wr_en_i && (addr_i == ADDR_W'(OFS_ENABLE));
    clr_pick_o  = pick;
    clr_vec_o   = pick | {SRC_W{clr_all_o}};
  end

  always_comb begin
    rd_sel_o = RS_NONE;
    if (rd_en_i) begin
      if (addr_i == ADDR_W'(OFS_MSTAT))        rd_sel_o = RS_MSTAT;
      else if (addr_i == ADDR_W'(OFS_ENABLE))  rd_sel_o = RS_ENABLE;
      else if (addr_i == ADDR_W'(OFS_RAW))     rd_sel_o = RS_RAW;
      else if (addr_i == ADDR_W'(OFS_CLR_ALL)) rd_sel_o = RS_CLR_ALL;
      else if (addr_i == ADDR_W'(OFS_ABORT))   rd_sel_o = RS_ABORT;
      else if (|pick)                          rd_sel_o = RS_CLR_ONE;
    end
  end

  // At most one individual clear decoded per access
  assert_one_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_pick_o));
  // Level-driven sources are never the target of a clear
  assert_level_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pick_o & LEVEL_MASK) == '0);
endmodule

// File: rtl/ic_irq_latch.sv
module ic_irq_latch
  import ic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_i,
  input  logic [SRC_W-1:0] clr_i,
  input  logic             rx_full_i,
  input  logic             tx_empty_i,
  output logic [SRC_W-1:0] raw_o
);
  logic [SRC_W-1:0] lat_q, lat_d;

  always_comb begin
    lat_d = (set_i & ~LEVEL_MASK) | (lat_q & ~clr_i & ~LEVEL_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  for (genvar i = 0; i < SRC_W; i++) begin : g_raw
    if (i == B_RX_FULL) begin : g_rxf
      assign raw_o[i] = rx_full_i;
    end else if (i == B_TX_EMPTY) begin : g_txe
      assign raw_o[i] = tx_empty_i;
    end else begin : g_lat
      assign raw_o[i] = lat_q[i];

      assert_event_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> raw_o[i]);
      assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !raw_o[i]);
      assert_quiet_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i[i] && !set_i[i]) |=> $stable(raw_o[i]));
    end
  end
endmodule

// File: rtl/ic_irq_abort.sv
module ic_irq_abort #(
  parameter int unsigned CAUSE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abrt_evt_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               clr_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d, cause_new;

  always_comb begin
    cause_new = abrt_evt_i ? cause_i : '0;
    cause_d   = (clr_i ? '0 : cause_q) | cause_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  assert_abort_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abrt_evt_i |=> ((cause_o & $past(cause_i)) == $past(cause_i)));
  assert_abort_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !abrt_evt_i) |=> (cause_o == '0));
  assert_abort_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !abrt_evt_i) |=> $stable(cause_o));
endmodule

// File: rtl/ic_irq_bank.sv
module ic_irq_bank
  import ic_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CAUSE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [SRC_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [SRC_W-1:0]   evt_i,
  input  logic               rx_full_i,
  input  logic               tx_empty_i,
  input  logic [CAUSE_W-1:0] abort_cause_i,
  output logic               irq_o
);
  logic [SRC_W-1:0]   clr_vec, clr_pick, raw, masked;
  logic               clr_all, abort_clr, enable_we;
  rd_sel_e            rd_sel;
  logic [SRC_W-1:0]   enable_q, enable_d;
  logic [DATA_W-1:0]  rd_q, rd_d;
  logic [CAUSE_W-1:0] cause;

  ic_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (addr_i),
    .rd_en_i     (rd_en_i),
    .wr_en_i     (wr_en_i),
    .clr_vec_o   (clr_vec),
    .clr_pick_o  (clr_pick),
    .clr_all_o   (clr_all),
    .abort_clr_o (abort_clr),
    .enable_we_o (enable_we),
    .rd_sel_o    (rd_sel)
  );

  ic_irq_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_i),
    .clr_i      (clr_vec),
    .rx_full_i  (rx_full_i),
    .tx_empty_i (tx_empty_i),
    .raw_o      (raw)
  );

  ic_irq_abort #(.CAUSE_W(CAUSE_W)) u_abort (
    .clk        (clk),
    .rst_n      (rst_n),
    .abrt_evt_i (evt_i[B_TX_ABRT]),
    .cause_i    (abort_cause_i),
    .clr_i      (abort_clr),
    .cause_o    (cause)
  );

  // Enable word: written only through its own offset
  always_comb begin
    enable_d = enable_q;
    if (enable_we) enable_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_q <= '0;
    else        enable_q <= enable_d;
  end

  always_comb masked = raw & enable_q;

  // Read mux samples pre-clear state
  always_comb begin
    rd_d = rd_q;
    unique case (rd_sel)
      RS_MSTAT:   rd_d = DATA_W'(masked);
      RS_ENABLE:  rd_d = DATA_W'(enable_q);
      RS_RAW:     rd_d = DATA_W'(raw);
      RS_CLR_ONE: rd_d = DATA_W'(|(raw & clr_pick));
      RS_CLR_ALL: rd_d = DATA_W'(|(raw & ~LEVEL_MASK));
      RS_ABORT:   rd_d = DATA_W'(cause);
      default:    rd_d = rd_en_i ? '0 : rd_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
  assign irq_o     = |masked;

  assert_no_irq_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq_o);
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> ((raw & ~LEVEL_MASK & ~$past(evt_i)) == '0));
  assert_enable_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_we |=> $stable(enable_q));
endmodule

// File: tb/sim_ic_irq_bank.sv
module sim_ic_irq_bank;
  logic        clk;
  logic        rst_n;
  logic [7:0]  addr;
  logic        rd_en, wr_en;
  logic [11:0] wr_data;
  logic [31:0] rd_data;
  logic [11:0] evt;
  logic        rx_full, tx_empty;
  logic [11:0] cause;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  ic_irq_bank u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_i        (addr),
    .rd_en_i       (rd_en),
    .wr_en_i       (wr_en),
    .wr_data_i     (wr_data),
    .rd_data_o     (rd_data),
    .evt_i         (evt),
    .rx_full_i     (rx_full),
    .tx_empty_i    (tx_empty),
    .abort_cause_i (cause),
    .irq_o         (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Fields: evt(12) rxf(1) txe(1) enable(12) exp_raw(12) exp_masked(12) exp_irq(1)
  localparam logic [50:0] TBL [0:5] = '{
    {12'h001, 1'b0, 1'b0, 12'hFFF, 12'h001, 12'h001, 1'b1},
    {12'h014, 1'b0, 1'b0, 12'hFFF, 12'h000, 12'h000, 1'b0},
    {12'h800, 1'b1, 1'b0, 12'h004, 12'h804, 12'h004, 1'b1},
    {12'hAAA, 1'b0, 1'b1, 12'h555, 12'hABA, 12'h010, 1'b1},
    {12'h3C0, 1'b0, 1'b0, 12'h03F, 12'h3C0, 12'h000, 1'b0},
    {12'hFFF, 1'b1, 1'b1, 12'h000, 12'hFFF, 12'h000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [11:0] ev, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1; evt = ev;
    @(negedge clk);
    rd_en = 1'b0; evt = '0;
    d = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [11:0] v);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] ev, input logic [11:0] c);
    @(negedge clk);
    evt = ev; cause = c;
    @(negedge clk);
    evt = '0; cause = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [11:0] exp;
    rst_n = 1'b0; addr = '0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    evt = '0; rx_full = 1'b0; tx_empty = 1'b0; cause = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    chk("R11 reset rd_data", rd_data, 32'h0);
    chk("R4 reset irq", {31'h0, irq}, 32'h0);
    rd(8'h30, '0, d); chk("R4 reset enable", d, 32'h0);
    rd(8'h34, '0, d); chk("R1 reset raw", d, 32'h0);

    // Table walk: R1 R2 R3 R5
    for (int r = 0; r < 6; r++) begin
      logic [50:0] v;
      v = TBL[r];
      rd(8'h40, '0, d);
      wr(8'h30, v[36:25]);
      rx_full = v[38]; tx_empty = v[37];
      pulse(v[50:39], '0);
      rd(8'h34, '0, d); chk($sformatf("R1 R2 R3 raw row%0d", r), d, {20'h0, v[24:13]});
      rd(8'h2C, '0, d); chk($sformatf("R5 masked row%0d", r), d, {20'h0, v[12:1]});
      chk($sformatf("R5 irq row%0d", r), {31'h0, irq}, {31'h0, v[0]});
    end

    // R3: levels survive clears
    rd(8'h40, '0, d);
    rd(8'h34, '0, d); chk("R3 levels after clear-all", d, 32'h014);
    rx_full = 1'b0; tx_empty = 1'b0;
    rd(8'h34, '0, d); chk("R3 levels follow input", d, 32'h0);

    // R6: walk individual clears in ascending latched-bit order
    wr(8'h30, 12'h000);
    pulse(12'hFFF, '0);
    exp = 12'hFEB;
    begin
      int k;
      k = 0;
      for (int b = 0; b < 12; b++) begin
        if (b != 2 && b != 4) begin
          rd(8'h44 + 8'(4 * k), '0, d);
          chk($sformatf("R6 clear ret bit%0d", b), d, 32'h1);
          exp[b] = 1'b0;
          rd(8'h34, '0, d);
          chk($sformatf("R6 raw after clear bit%0d", b), d, {20'h0, exp});
          k++;
        end
      end
    end
    rd(8'h44, '0, d); chk("R6 clear of empty bit returns 0", d, 32'h0);

    // R7: combined clear
    pulse(12'h3A3, '0);
    rd(8'h40, '0, d); chk("R7 clear-all return", d, 32'h1);
    rd(8'h34, '0, d); chk("R7 raw after clear-all", d, 32'h0);
    rd(8'h40, '0, d); chk("R7 clear-all empty return", d, 32'h0);

    // R8: event coincident with its clear
    rd(8'h60, 12'h200, d);
    rd(8'h34, '0, d); chk("R8 event kept on individual clear", d, 32'h200);
    rd(8'h40, 12'h001, d);
    rd(8'h34, '0, d); chk("R8 event kept on clear-all", d, 32'h001);
    rd(8'h40, '0, d);

    // R9 R10: abort cause
    pulse(12'h040, 12'h089);
    rd(8'h80, '0, d); chk("R9 abort cause captured", d, 32'h089);
    pulse(12'h040, 12'h800);
    rd(8'h80, '0, d); chk("R9 abort cause accumulates", d, 32'h889);
    pulse(12'h000, 12'h00F);
    rd(8'h80, '0, d); chk("R9 cause ignored without abort", d, 32'h889);
    rd(8'h40, '0, d);
    rd(8'h80, '0, d); chk("R10 cause kept by clear-all", d, 32'h889);
    rd(8'h54, '0, d); chk("R10 abort clear returns bit", d, 32'h0);
    rd(8'h80, '0, d); chk("R10 cause cleared by abort clear", d, 32'h0);
    @(negedge clk);
    addr = 8'h54; rd_en = 1'b1; evt = 12'h040; cause = 12'h002;
    @(negedge clk);
    rd_en = 1'b0; evt = '0; cause = '0;
    rd(8'h80, '0, d); chk("R10 new cause survives same-cycle clear", d, 32'h002);
    rd(8'h34, '0, d); chk("R8 abort bit kept on same-cycle clear", d, 32'h040);

    // R11: unmapped reads, ignored writes, hold
    rd(8'h10, '0, d); chk("R11 unmapped read zero", d, 32'h0);
    wr(8'h34, 12'hFFF);
    wr(8'h2C, 12'hFFF);
    rd(8'h34, '0, d); chk("R11 write to raw ignored", d, 32'h040);
    rd(8'h30, '0, d); chk("R11 enable unchanged", d, 32'h0);
    wr(8'h30, 12'h040);
    repeat (2) @(negedge clk);
    chk("R11 rd_data held", rd_data, 32'h0);
    chk("R5 irq on enabled abort", {31'h0, irq}, 32'h1);
    rd(8'h54, '0, d);
    chk("R5 irq drops after clear", {31'h0, irq}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule